// File: doc/BRIEF.md
# Nested Priority Interrupt Controller for General-Purpose Levels

This block decides which general-purpose interrupt level a small processor core should enter next. It covers four levels, numbered 11 to 14. Level 11 has the highest priority. Three registers hold its state. The first latches software-raised requests that are still waiting. The second is the enable mask written by the core's global enable and disable operations. The third records which levels have been entered and not yet left.

A waiting level is serviced only when it is enabled and outranks every level already in service. The exception is self-nesting. When the core's self-nesting configuration bit (bit 2 of its system configuration word) is set, the level currently in service may be re-entered if it is raised again. Each entry is offered on a valid/ready channel and carries three things:
- the level number;
- the byte offset of that level's vector word, with vectors 4 bytes apart starting from level 11 at offset 0;
- the word to save as the return address.

Bit 0 of the saved word flags a self-nested entry. When the handler returns, the core passes that bit back with the return strobe. If the bit is set, the in-service record is left unchanged. If it is clear, the current level is unwound.

Back-pressure rules on the entry channel are as follows. Once `ent_valid` rises, the level, offset and word stay frozen until the core accepts them with `ent_ready` in the same cycle. A later raise or mask change never withdraws or alters an offer. Nothing is committed until acceptance: the waiting bit clears and the in-service bit sets only on the accepting clock edge. The return strobe has no handshake. Each pulse is one return.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, nothing is waiting, nothing is in service and the mask is all zero, so `ent_valid` is 0.
- R2: A raise in `raise_vec` (bit k means level 11+k) sets that level's waiting bit at the next edge. With the level enabled and nothing in service, `ent_valid` rises at the edge after that. The offer shows `ent_level` = 11+k and `ent_voff` = 4*k.
- R3: When several enabled levels wait together, the lowest-numbered one is offered first.
- R4: A waiting level whose mask bit is 0 is never offered. `gie_set` loads the mask from `mask_wdata` (bit k means level 11+k). `gie_clr` clears the whole mask and wins when both are pulsed together.
- R5: While `ent_valid` is 1 and `ent_ready` is 0, the offer's level, offset and word hold steady, even if a higher-priority level is raised. Acceptance clears that level's waiting bit, unless the same level is raised in the accepting cycle, in which case the bit stays set.
- R6: A level that is waiting and enabled is offered only if it has a lower number than every level in service. Otherwise it stays waiting.
- R7: With `self_nest_en` at 0, raising the level in service does not re-enter it. The raise stays waiting and is offered again after a return with bit 0 clear.
- R8: With `self_nest_en` at 1, raising the level currently in service re-enters it, and `ent_word` bit 0 is 1. For any other entry, `ent_word` bit 0 is 0. `ent_word[31:1]` is always `ret_pc_hi` as sampled when the offer was made.
- R9: A return with `rti_lsb` = 1 leaves the in-service record unchanged, whatever `self_nest_en` is. A return with `rti_lsb` = 0 clears the in-service bit of the lowest-numbered level in service, after which the best remaining waiting and enabled level is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| raise_vec | input | 4 | Software raise, one bit per level 11..14 |
| gie_set | input | 1 | Global enable: load mask from `mask_wdata` |
| gie_clr | input | 1 | Global disable: clear mask |
| mask_wdata | input | 4 | Mask value for `gie_set` |
| self_nest_en | input | 1 | Self-nesting allowed |
| ret_pc_hi | input | 31 | Upper bits of the interrupted return address |
| rti_strb | input | 1 | Return-from-interrupt pulse |
| rti_lsb | input | 1 | Bit 0 of the return address given with the return |
| ent_valid | output | 1 | An entry is offered |
| ent_ready | input | 1 | Core accepts the offered entry |
| ent_level | output | 4 | Level number of the offer |
| ent_voff | output | 4 | Byte offset of the level's vector word |
| ent_word | output | 32 | Return word to save; bit 0 marks self-nesting |

## Verification
Two events can fall in the same cycle. One is the acceptance of an offered entry. The other is a new software raise of the very same level. To provoke this, the bench holds an offer for level 14 with `ent_ready` low, then drives ready and the raise of level 14 in one cycle. The scoreboard then expects no re-entry while 14 is in service with self-nesting off, and a second level-14 entry right after the return. A lost raise shows up as a missing scoreboard item, and a wrong re-entry as an unexpected one.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // How a return treats the in-service record, decided by bit 0 of its word
  typedef enum logic {
    RET_UNWIND = 1'b0,
    RET_HOLD   = 1'b1
  } ret_kind_e;

  localparam int EVC_BASE_LVL = 11;
  localparam int EVC_NUM_LVL  = 4;
  localparam int EVC_STRIDE   = 4;
  localparam int EVC_AW       = 32;
endpackage

// File: rtl/evc_pend_mask.sv
module evc_pend_mask #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise_vec,
  input  logic [N-1:0] acc_vec,
  input  logic         gie_set,
  input  logic         gie_clr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] mask_q
);

  // one waiting flop per level; a raise outranks the clear on acceptance
  for (genvar g = 0; g < N; g++) begin : g_lvl
    logic wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wait_q <= 1'b0;
      else if (raise_vec[g]) wait_q <= 1'b1;
      else if (acc_vec[g])   wait_q <= 1'b0;
    end
    assign pend_q[g] = wait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (gie_clr) mask_q <= '0;
    else if (gie_set) mask_q <= mask_wdata;
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> (mask_q == '0)); // R4

  AST_ACCEPT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_vec & ~raise_vec) != '0) |=> ((pend_q & $past(acc_vec & ~raise_vec)) == '0)); // R5

endmodule

// File: rtl/evc_active.sv
module evc_active
  import evc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] acc_vec,
  input  logic         rti_strb,
  input  logic         rti_lsb,
  output logic [N-1:0] active_q,
  output logic [N-1:0] cur_vec
);

  ret_kind_e    ret_kind;
  logic [N-1:0] drop_vec;
  logic [N-1:0] active_d;

  // current level: lowest-numbered bit in service
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      cur_vec[i] = active_q[i] & ~seen;
      seen       = seen | active_q[i];
    end
  end

  assign ret_kind = ret_kind_e'(rti_lsb);
  assign drop_vec = (rti_strb && ret_kind == RET_UNWIND) ? cur_vec : '0;
  assign active_d = (active_q & ~drop_vec) | acc_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_strb && rti_lsb && acc_vec == '0) |=> (active_q == $past(active_q))); // R9

  AST_UNWIND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_strb && !rti_lsb && active_q != '0 && acc_vec == '0)
      |=> ($countones(active_q) == $countones($past(active_q)) - 1)); // R9

endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     pend_q,
  input  logic [N-1:0]     mask_q,
  input  logic [N-1:0]     active_q,
  input  logic [N-1:0]     cur_vec,
  input  logic             self_nest_en,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_self
);

  logic [N-1:0] cand;
  logic [N-1:0] outranks;
  logic [N-1:0] self_ok;
  logic [N-1:0] elig;

  assign cand    = pend_q & mask_q;
  assign self_ok = cur_vec & {N{self_nest_en}};

  // a level outranks the stack when nothing at its number or below is in service
  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < N; i++) begin
      blk         = blk | active_q[i];
      outranks[i] = ~blk;
    end
  end

  assign elig = cand & (outranks | self_ok);

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  assign pick_self = self_ok[pick_idx];

endmodule

// File: rtl/evc_offer.sv
module evc_offer #(
  parameter int N        = 4,
  parameter int IDX_W    = 2,
  parameter int AW       = 32,
  parameter int BASE_LVL = 11,
  parameter int STRIDE   = 4,
  parameter int LVL_W    = 4,
  parameter int OFF_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_vld,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             pick_self,
  input  logic [AW-1:1]    ret_pc_hi,
  input  logic             ent_ready,
  output logic             ent_valid,
  output logic [LVL_W-1:0] ent_level,
  output logic [OFF_W-1:0] ent_voff,
  output logic [AW-1:0]    ent_word,
  output logic [N-1:0]     off_vec
);

  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    word_q;

  // capture into an empty slot; hold until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (!vld_q) begin
      if (pick_vld) begin
        vld_q  <= 1'b1;
        idx_q  <= pick_idx;
        word_q <= {ret_pc_hi, pick_self};
      end
    end else if (ent_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_comb begin
    off_vec        = '0;
    off_vec[idx_q] = 1'b1;
  end

  assign ent_valid = vld_q;
  assign ent_level = LVL_W'(BASE_LVL) + LVL_W'(idx_q);
  assign ent_voff  = OFF_W'(idx_q) * OFF_W'(STRIDE);
  assign ent_word  = word_q;

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_level) && $stable(ent_word))); // R5

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import evc_pkg::*;
#(
  parameter int N        = EVC_NUM_LVL,
  parameter int BASE_LVL = EVC_BASE_LVL,
  parameter int STRIDE   = EVC_STRIDE,
  parameter int AW       = EVC_AW,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int LVL_W   = $clog2(BASE_LVL + N),
  localparam int OFF_W   = $clog2(N * STRIDE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     raise_vec,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic [N-1:0]     mask_wdata,
  input  logic             self_nest_en,
  input  logic [AW-1:1]    ret_pc_hi,
  input  logic             rti_strb,
  input  logic             rti_lsb,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [LVL_W-1:0] ent_level,
  output logic [OFF_W-1:0] ent_voff,
  output logic [AW-1:0]    ent_word
);

  logic [N-1:0]     pend_q, mask_q, active_q, cur_vec, off_vec, acc_vec;
  logic             pick_vld, pick_self;
  logic [IDX_W-1:0] pick_idx;

  assign acc_vec = off_vec & {N{ent_valid & ent_ready}};

  evc_pend_mask #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise_vec(raise_vec), .acc_vec(acc_vec),
    .gie_set(gie_set), .gie_clr(gie_clr), .mask_wdata(mask_wdata),
    .pend_q(pend_q), .mask_q(mask_q)
  );

  evc_active #(.N(N)) u_active (
    .clk(clk), .rst_n(rst_n), .acc_vec(acc_vec), .rti_strb(rti_strb),
    .rti_lsb(rti_lsb), .active_q(active_q), .cur_vec(cur_vec)
  );

  evc_arbiter #(.N(N), .IDX_W(IDX_W)) u_arb (
    .pend_q(pend_q), .mask_q(mask_q), .active_q(active_q), .cur_vec(cur_vec),
    .self_nest_en(self_nest_en), .pick_vld(pick_vld), .pick_idx(pick_idx),
    .pick_self(pick_self)
  );

  evc_offer #(.N(N), .IDX_W(IDX_W), .AW(AW), .BASE_LVL(BASE_LVL),
              .STRIDE(STRIDE), .LVL_W(LVL_W), .OFF_W(OFF_W)) u_offer (
    .clk(clk), .rst_n(rst_n), .pick_vld(pick_vld), .pick_idx(pick_idx),
    .pick_self(pick_self), .ret_pc_hi(ret_pc_hi), .ent_ready(ent_ready),
    .ent_valid(ent_valid), .ent_level(ent_level), .ent_voff(ent_voff),
    .ent_word(ent_word), .off_vec(off_vec)
  );

  // a plain (non-self-nested) offer never names a level already in service
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_word[0]) |-> ((off_vec & active_q) == '0)); // R7

  // an offered level was enabled-independent but must have been waiting or just taken
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) |-> ($past(pend_q) != '0)); // R1

endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  raise_vec = '0, mask_wdata = '0;
  logic        gie_set = 0, gie_clr = 0, self_nest_en = 0;
  logic [31:1] ret_pc_hi = '0;
  logic        rti_strb = 0, rti_lsb = 0, ent_ready = 1;
  logic        ent_valid;
  logic [3:0]  ent_level, ent_voff;
  logic [31:0] ent_word;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [3:0]  lvl;
    logic [3:0]  voff;
    logic [31:0] word;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .raise_vec(raise_vec), .gie_set(gie_set),
    .gie_clr(gie_clr), .mask_wdata(mask_wdata), .self_nest_en(self_nest_en),
    .ret_pc_hi(ret_pc_hi), .rti_strb(rti_strb), .rti_lsb(rti_lsb),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_level(ent_level),
    .ent_voff(ent_voff), .ent_word(ent_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ent(input int lvl, input bit self_flag, input string tag);
    exp_t e;
    e.lvl  = 4'(lvl);
    e.voff = 4'((lvl - 11) * 4);
    e.word = {ret_pc_hi, self_flag};
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(input logic [3:0] v);
    raise_vec = v; @(negedge clk); raise_vec = '0;
  endtask

  task automatic rti(input bit lsb);
    rti_strb = 1; rti_lsb = lsb; @(negedge clk); rti_strb = 0; rti_lsb = 0;
  endtask

  task automatic sti(input logic [3:0] m);
    gie_set = 1; mask_wdata = m; @(negedge clk); gie_set = 0;
  endtask

  task automatic idle_chk(input string tag);
    #2 check(ent_valid == 1'b0, tag, 32'(ent_valid), 32'h0);
  endtask

  // monitor: every accepted entry is compared with the scoreboard head
  always begin
    @(negedge clk);
    #2;
    if (rst_n && ent_valid && ent_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4/R6/R7 unexpected entry", 32'(ent_level), 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(ent_level == e.lvl && ent_voff == e.voff && ent_word == e.word,
              e.tag, {ent_level, ent_voff, ent_word[23:0]}, {e.lvl, e.voff, e.word[23:0]});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    idle_chk("R1 idle after reset");
    tick(1);
    sti(4'b1101);                       // 11,13,14 enabled; 12 not

    // several waiting levels, priority and return order
    ret_pc_hi = 31'h0800_1234;
    expect_ent(11, 0, "R3 lowest number first");
    raise(4'b1111);
    tick(5);
    idle_chk("R6 lower levels wait behind 11");
    expect_ent(13, 0, "R9 unwind offers next best");
    rti(0); tick(5);
    expect_ent(14, 0, "R9 unwind offers 14");
    rti(0); tick(5);
    rti(0); tick(5);
    idle_chk("R4 masked 12 never offered");

    // latency, hold under back-pressure, preemption
    ent_ready = 0;
    ret_pc_hi = 31'h0200_0050;
    expect_ent(13, 0, "R2 entry 13 accepted");
    raise(4'b0100);
    idle_chk("R2 no offer one edge after raise");
    @(negedge clk); #2;
    check(ent_valid && ent_level == 4'd13 && ent_voff == 4'd8, "R2 offer level/offset",
          {ent_valid, ent_level, ent_voff}, {1'b1, 4'd13, 4'd8});
    @(negedge clk);
    expect_ent(11, 0, "R6 11 preempts 13");
    raise(4'b0001);
    tick(2); #2;
    check(ent_valid && ent_level == 4'd13 && ent_word == {31'h0200_0050, 1'b0},
          "R5 offer held under back-pressure", {ent_level, ent_word[27:0]}, {4'd13, 28'h400_00A0});
    @(negedge clk);
    ent_ready = 1;
    tick(6);
    rti(0); tick(3);
    rti(0); tick(3);

    // acceptance and raise of the same level together
    ent_ready = 0;
    expect_ent(14, 0, "R5 first 14 entry");
    raise(4'b1000);
    tick(3);
    ent_ready = 1;
    raise(4'b1000);
    tick(5);
    idle_chk("R7 no self re-entry of 14");
    expect_ent(14, 0, "R5 raise kept through acceptance");
    rti(0); tick(5);
    rti(0); tick(3);
    idle_chk("R5 nothing left waiting");

    // self raise with nesting off
    expect_ent(11, 0, "R2 entry 11");
    raise(4'b0001); tick(4);
    raise(4'b0001); tick(5);
    idle_chk("R7 raise of 11 in service waits");
    expect_ent(11, 0, "R7 retaken after return");
    rti(0); tick(5);
    rti(0); tick(3);

    // self-nesting on
    self_nest_en = 1;
    ret_pc_hi = 31'h1111_1110;
    expect_ent(11, 0, "R8 plain entry flag 0");
    raise(4'b0001); tick(4);
    expect_ent(11, 1, "R8 nested entry flag 1");
    raise(4'b0001); tick(5);
    raise(4'b0100); tick(3);
    idle_chk("R6 13 waits under 11");
    rti(1); tick(5);
    idle_chk("R9 flagged return keeps 11");
    expect_ent(13, 0, "R9 unwind then 13");
    rti(0); tick(5);
    rti(0); tick(3);
    self_nest_en = 0;

    // flagged return with nesting off
    expect_ent(13, 0, "R9 entry 13");
    raise(4'b0100); tick(4);
    raise(4'b1000); tick(3);
    rti(1); tick(5);
    idle_chk("R9 flag keeps 13 with nesting off");
    expect_ent(14, 0, "R9 14 after plain return");
    rti(0); tick(5);
    rti(0); tick(3);

    // global disable / enable
    gie_clr = 1; @(negedge clk); gie_clr = 0;
    raise(4'b0001); tick(4);
    idle_chk("R4 cleared mask blocks 11");
    gie_clr = 1; gie_set = 1; mask_wdata = 4'hF; @(negedge clk);
    gie_clr = 0; gie_set = 0;
    tick(4);
    idle_chk("R4 disable wins over enable");
    expect_ent(11, 0, "R4 enable releases 11");
    sti(4'b0001); tick(5);
    rti(0); tick(3);
    expect_ent(12, 0, "R4 enabling 12 offset 4");
    sti(4'b0010); tick(5);
    rti(0); tick(3);

    #2 check(sb.size() == 0, "R5 every expected entry seen", 32'(sb.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule